// File: doc/BRIEF.md
# Time-Mode Weighted Delay Chain Neuron

This block models one race-logic neuron as clocked digital logic. Sixty-four multiply stages are wired in a chain. Each stage holds a busy pulse for a number of clock cycles. That number is the product of a per-pixel factor and a per-stage weight term, so the neuron's weighted sum is carried as elapsed time rather than as a stored value.

A stage hands off to the next stage when its pulse ends. It does this through a short trigger pulse of fixed width, so the stage durations add up along the chain. A one-cycle begin strobe starts the first trigger. When the last stage finishes, a done pulse of the same fixed width marks the arrival time of the final edge. Neurons that finish earlier rank higher when several of them race against each other.

For checking, the block also reports the number of cycles the chain was active during the most recent run.

Top module: `tm_neuron`

## Requirements
- R1: While reset is asserted and after it is released, `done_o` and `busy_o` are low and `total_cycles_o` is zero.
- R2: Stage i runs for (3 + p_i)·(w_i + 1) cycles. Here p_i is the 2-bit pixel code at `pixel_i[2i+1:2i]` (0 = black, 1 = white, 2 and 3 are darker-than-white greys) and w_i is the unsigned 4-bit weight at `weight_i[4i+3:4i]`.
- R3: A run keeps the chain active for exactly T = Σ(3 + p_i)·(w_i + 1) + 64·TRIG_W contiguous cycles, with no gap. At most one trigger or stage is active in any cycle.
- R4: A begin strobe sampled high while idle is accepted at that clock edge. `done_o` first reads high after the (T+1)-th rising edge, counting the accepting edge as the first, and stays high for exactly TRIG_W cycles.
- R5: A begin strobe sampled while `busy_o` is high has no effect. This includes strobes during the chain run and strobes during the done pulse.
- R6: A stage whose weight code is zero still runs for one full unit (3 + p_i cycles) and then ends, so the chain never stalls.
- R7: The total depends only on the set of stage durations, not on their order along the chain.
- R8: After a run, `total_cycles_o` holds T until the next accepted begin strobe clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| begin_i | input | 1 | Begin strobe, one cycle wide |
| pixel_i | input | 128 | 64 pixel codes, 2 bits per stage, stage 0 in the lowest bits |
| weight_i | input | 256 | 64 weight codes, 4 bits per stage, stage 0 in the lowest bits |
| done_o | output | 1 | Done pulse, TRIG_W cycles wide; its falling edge marks the result |
| busy_o | output | 1 | High while the chain or the done pulse is active |
| total_cycles_o | output | 13 | Number of cycles the chain was active in the latest run |

## Verification
The bench measures arrival time on several pixel and weight patterns: all-minimum, all-maximum, mixed greys, a single heavy stage, and a reversed ordering. A design that dropped the extra weight unit, miscounted the trigger cycles or left a gap between hand-offs would shift the done edge and the reported total. Begin strobes are also injected mid-run and in the same cycle as the done pulse. A design that re-armed on either of these would restart the chain, clear the count, or produce a second done pulse. Checks that the count still holds after idle time catch a counter that keeps running or clears itself early.

// File: rtl/tm_neuron_pkg.sv
package tm_neuron_pkg;
  localparam int PIX_W    = 2;
  localparam int WGT_W    = 4;
  localparam int BASE_CYC = 3;
  localparam int MAX_FACT = BASE_CYC + (1 << PIX_W) - 1;
  localparam int MAX_STG  = MAX_FACT * (1 << WGT_W);
  localparam int STG_CW   = $clog2(MAX_STG + 1);

  // cycles per unit for a pixel code
  function automatic logic [STG_CW-1:0] pix_factor(input logic [PIX_W-1:0] pix);
    return STG_CW'(pix) + STG_CW'(BASE_CYC);
  endfunction

  // stage duration: factor times (weight + the fixed extra unit)
  function automatic logic [STG_CW-1:0] stage_cycles(input logic [PIX_W-1:0] pix,
                                                     input logic [WGT_W-1:0] wgt);
    logic [STG_CW-1:0] units;
    units = STG_CW'(wgt) + STG_CW'(1);
    return pix_factor(pix) * units;
  endfunction
endpackage

// File: rtl/tm_pulse_gen.sv
module tm_pulse_gen #(
  parameter int WIDTH = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic act_o,
  output logic last_o
);
  localparam int CW = $clog2(WIDTH + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (fire_i)      cnt <= CW'(WIDTH);
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end

  assign act_o  = (cnt != '0);
  assign last_o = (cnt == CW'(1));
endmodule

// File: rtl/tm_stage.sv
module tm_stage
  import tm_neuron_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic [WGT_W-1:0]  wgt_i,
  output logic              act_o,
  output logic              last_o
);
  logic [STG_CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (start_i)   cnt <= stage_cycles(pix_i, wgt_i);
    else if (cnt != '0) cnt <= cnt - STG_CW'(1);
  end

  assign act_o  = (cnt != '0);
  assign last_o = (cnt == STG_CW'(1));
endmodule

// File: rtl/tm_neuron.sv
module tm_neuron
  import tm_neuron_pkg::*;
#(
  parameter int N_STAGES = 64,
  parameter int TRIG_W   = 1,
  localparam int TOT_CW  = $clog2(N_STAGES * (TRIG_W + MAX_STG) + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        begin_i,
  input  logic [N_STAGES*PIX_W-1:0]   pixel_i,
  input  logic [N_STAGES*WGT_W-1:0]   weight_i,
  output logic                        done_o,
  output logic                        busy_o,
  output logic [TOT_CW-1:0]           total_cycles_o
);
  logic [N_STAGES-1:0] trig_act, trig_last;
  logic [N_STAGES-1:0] stage_act, stage_last;
  logic                chain_busy;
  logic                accept;
  logic                done_last;
  logic [TOT_CW-1:0]   total_q;

  assign chain_busy = (|trig_act) | (|stage_act);
  assign busy_o     = chain_busy | done_o;
  assign accept     = begin_i & ~busy_o;

  for (genvar i = 0; i < N_STAGES; i++) begin : g_link
    logic fire;
    if (i == 0) begin : g_head
      assign fire = accept;
    end else begin : g_body
      assign fire = stage_last[i-1];
    end

    tm_pulse_gen #(.WIDTH(TRIG_W)) u_trig (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire_i (fire),
      .act_o  (trig_act[i]),
      .last_o (trig_last[i])
    );

    tm_stage u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (trig_last[i]),
      .pix_i   (pixel_i[i*PIX_W +: PIX_W]),
      .wgt_i   (weight_i[i*WGT_W +: WGT_W]),
      .act_o   (stage_act[i]),
      .last_o  (stage_last[i])
    );
  end

  tm_pulse_gen #(.WIDTH(TRIG_W)) u_done (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire_i (stage_last[N_STAGES-1]),
    .act_o  (done_o),
    .last_o (done_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          total_q <= '0;
    else if (accept)     total_q <= '0;
    else if (chain_busy) total_q <= total_q + TOT_CW'(1);
  end

  assign total_cycles_o = total_q;

  logic unused_ok;
  assign unused_ok = done_last;
endmodule

// File: rtl/tm_neuron_chk.sv
module tm_neuron_chk #(
  parameter int N_STAGES = 64,
  parameter int TOT_CW   = 13
) (
  input logic                clk,
  input logic                rst_n,
  input logic                begin_i,
  input logic                done_o,
  input logic                busy_o,
  input logic [TOT_CW-1:0]   total_cycles_o,
  input logic [N_STAGES-1:0] trig_act,
  input logic [N_STAGES-1:0] stage_act
);
  logic any_act;
  assign any_act = (|trig_act) | (|stage_act);

  p_single_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trig_act, stage_act}));

  p_no_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(any_act) |-> done_o);

  p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (begin_i && !busy_o) |=> trig_act[0]);

  p_done_follows_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(stage_act[N_STAGES-1]));

  p_ignore_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (begin_i && busy_o) |=> !$rose(trig_act[0]));

  p_total_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !begin_i) |=> $stable(total_cycles_o));

  p_idle_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !done_o);
endmodule

bind tm_neuron tm_neuron_chk #(.N_STAGES(N_STAGES), .TOT_CW(TOT_CW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .begin_i        (begin_i),
  .done_o         (done_o),
  .busy_o         (busy_o),
  .total_cycles_o (total_cycles_o),
  .trig_act       (trig_act),
  .stage_act      (stage_act)
);

// File: tb/tm_neuron_bench.sv
module tm_neuron_bench;
  localparam int NS = 64;
  localparam int TW = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic begin_i = 1'b0;
  logic [NS*2-1:0] pixel_i;
  logic [NS*4-1:0] weight_i;
  logic done_o, busy_o;
  logic [12:0] total_cycles_o;

  int pix [NS];
  int wgt [NS];
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      pixel_i[i*2 +: 2]  = pix[i][1:0];
      weight_i[i*4 +: 4] = wgt[i][3:0];
    end
  end

  tm_neuron u_tm_neuron (
    .clk(clk), .rst_n(rst_n), .begin_i(begin_i),
    .pixel_i(pixel_i), .weight_i(weight_i),
    .done_o(done_o), .busy_o(busy_o), .total_cycles_o(total_cycles_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_total();
    int acc = NS * TW;
    for (int i = 0; i < NS; i++) acc += (3 + pix[i]) * (wgt[i] + 1);
    return acc;
  endfunction

  // one run: optional begin poke mid-run, optional poke on the done cycle
  task automatic run_case(input string tag, input int poke_at, input bit poke_done);
    int t = expect_total();
    int n = 0;
    @(negedge clk);
    begin_i = 1'b1;
    while (1) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      begin_i = (n == poke_at);
      if (done_o) break;
      if (n > 20000) begin
        chk(0, {"R4 ", tag, " no done"}, n, t + 1);
        return;
      end
    end
    chk(n == t + 1, {"R4 ", tag, " arrival"}, n, t + 1);
    chk(total_cycles_o == 13'(t), {"R3 ", tag, " total"}, int'(total_cycles_o), t);
    if (poke_done) begin_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    begin_i = 1'b0;
    chk(!done_o, {"R4 ", tag, " done width"}, int'(done_o), 0);
    chk(!busy_o, {"R5 ", tag, " idle after done"}, int'(busy_o), 0);
    repeat (5) @(negedge clk);
    chk(total_cycles_o == 13'(t), {"R8 ", tag, " hold"}, int'(total_cycles_o), t);
    chk(!busy_o && !done_o, {"R5 ", tag, " no rerun"}, int'(busy_o), 0);
  endtask

  task automatic t_reset();
    chk(!done_o && !busy_o, "R1 reset flags", int'({done_o, busy_o}), 0);
    chk(total_cycles_o == '0, "R1 reset total", int'(total_cycles_o), 0);
  endtask

  task automatic t_min_weights();
    for (int i = 0; i < NS; i++) begin pix[i] = 0; wgt[i] = 0; end
    chk(expect_total() == 256, "R6 zero-weight model", expect_total(), 256);
    run_case("R6 all black zero weight", 0, 0);
  endtask

  task automatic t_max_weights();
    for (int i = 0; i < NS; i++) begin pix[i] = 1; wgt[i] = 15; end
    run_case("R2 all white max weight", 0, 0);
  endtask

  task automatic t_mixed();
    for (int i = 0; i < NS; i++) begin pix[i] = i % 4; wgt[i] = (i * 7) % 16; end
    run_case("R2 mixed greys", 0, 0);
  endtask

  task automatic t_single();
    for (int i = 0; i < NS; i++) begin pix[i] = 0; wgt[i] = 0; end
    pix[37] = 1; wgt[37] = 9;
    run_case("R2 single heavy stage", 0, 0);
  endtask

  task automatic t_reversed();
    int tmp [NS];
    for (int i = 0; i < NS; i++) begin pix[i] = i % 4; wgt[i] = (i * 7) % 16; end
    for (int i = 0; i < NS; i++) tmp[i] = wgt[i];
    for (int i = 0; i < NS; i++) wgt[i] = tmp[NS-1-i];
    for (int i = 0; i < NS; i++) tmp[i] = pix[i];
    for (int i = 0; i < NS; i++) pix[i] = tmp[NS-1-i];
    run_case("R7 reversed order", 0, 0);
  endtask

  task automatic t_ignore_mid();
    for (int i = 0; i < NS; i++) begin pix[i] = (i + 1) % 2; wgt[i] = i % 16; end
    run_case("R5 begin mid-run", 50, 0);
  endtask

  task automatic t_ignore_done();
    for (int i = 0; i < NS; i++) begin pix[i] = 2; wgt[i] = 3; end
    run_case("R5 begin on done", 0, 1);
  endtask

  task automatic t_reset_mid();
    for (int i = 0; i < NS; i++) begin pix[i] = 1; wgt[i] = 5; end
    @(negedge clk);
    begin_i = 1'b1;
    @(negedge clk);
    begin_i = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) begin pix[i] = 0; wgt[i] = 0; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_min_weights();
    t_max_weights();
    t_mixed();
    t_single();
    t_reversed();
    t_ignore_mid();
    t_ignore_done();
    t_reset_mid();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule